// File: doc/BRIEF.md
# Compressed Instruction Page-Stack Controller

This block tracks which page of short instruction encodings a processor front end should use. A page is a remapping of the compressed opcode space onto another operation set. Active pages sit on a small stack, and the top entry is the live one. Each entry pairs a subpage number with a lifetime code. A lifetime counts down once per retired instruction, and a taken branch ends the entry early. One lifetime code marks the page as permanent, and a permanent entry never counts down and is never removed by a branch.

The retire stage sends decoded events: select a page, drop the top page, clear every page, instruction retired, and branch taken. The block shows the live subpage number and a flag that is high while any page is stacked. It also presents its whole state as one packed control word. Software can read that word and write it back whole, which lets a caller save and restore the paging context around a call. A sticky flag reports a select that arrived while the stack was full.

Top module: `cpage_ctrl`

## Requirements
- R1: While `rst_n` is low, and just after it rises, the block is empty: `csr_rdata` is 0, and `page_active`, `act_sub` and `ovf` are all 0.
- R2: `sel_valid` with a nonzero `sel_len` pushes the entry {`sel_sub`,`sel_len`} above the current top and raises the depth by one. `act_sub` then shows `sel_sub` and `page_active` is 1. A select with `sel_len` equal to 0 changes nothing.
- R3: A select that arrives when 4 entries are already stacked is dropped and sets `ovf`. Once set, `ovf` stays high until reset or a control-word write.
- R4: A top entry whose length code is 15 (all ones) is permanent. Retire and taken-branch strobes neither shorten it nor remove it.
- R5: Each `retire` pulse lowers the length of a non-permanent top entry by one. A pulse that meets length 1 removes the entry in that same update.
- R6: `br_taken` removes a non-permanent top entry and does not shorten it. If `retire` comes in the same cycle, the entry that becomes the new top is left untouched.
- R7: `pop_cmd` removes only the top entry, which makes the entry beneath it live again. At depth 0 it has no effect.
- R8: `clr_cmd` empties the whole stack in one update, which returns the front end to the base instruction set.
- R9: Within one cycle, the removal caused by a branch or a retire is applied first, and the explicit command is applied to what remains. Among the commands, clear beats pop and pop beats select.
- R10: Control-word layout: entry i (0 = bottom) is at bits [7i+6:7i], with the subpage in the upper 3 bits and the length in the lower 4 bits. The depth is at [30:28] and bit 31 reads as 0. Entries at positions at or above the depth read as 0.
- R11: `csr_we` loads the entries and the depth from `csr_wdata` and overrides every other input in that cycle. A depth field above 4 is saturated to 4. The write also clears `ovf`.
- R12: At depth 0, `page_active` is low and `act_sub` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Page-select command |
| sel_sub | input | 3 | Subpage number to select |
| sel_len | input | 4 | Lifetime code (15 = permanent, 0 = ignored) |
| pop_cmd | input | 1 | Remove the top entry |
| clr_cmd | input | 1 | Empty the stack |
| retire | input | 1 | One instruction retired |
| br_taken | input | 1 | A branch was taken |
| csr_we | input | 1 | Write the packed control word |
| csr_wdata | input | 32 | Control word to load |
| csr_rdata | output | 32 | Packed live state |
| act_sub | output | 3 | Live subpage number |
| page_active | output | 1 | A page is stacked |
| ovf | output | 1 | Sticky select-while-full flag |

## Verification
The assertions assume that every input is a clean 0 or 1 at each clock edge after reset, and that any mix of strobes can occur in a cycle. That includes a command together with a branch and a retire, and a control-word write alongside commands. The assertions make no assumption about the write data, so depth codes 5 to 7 are legal inputs. The stimulus drives one set of values per cycle at the falling edge and deliberately overlaps strobes. It writes control words with out-of-range depths, and it pushes past full and pops below empty, so the priority and saturation rules are exercised rather than avoided.

// File: rtl/cpage_pkg.sv
package cpage_pkg;

   // Explicit command chosen for a cycle after priority resolution.
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_CLR  = 2'd1,
      CMD_POP  = 2'd2,
      CMD_PUSH = 2'd3
   } cmd_e;

   // Width of a depth counter that must hold 0..d inclusive.
   function automatic int unsigned depth_bits(input int unsigned d);
      return $clog2(d + 1);
   endfunction

endpackage

// File: rtl/cpage_cmd_arb.sv
module cpage_cmd_arb
   import cpage_pkg::*;
#(
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_cmd,
   input  logic             pop_cmd,
   input  logic             sel_valid,
   input  logic [LEN_W-1:0] sel_len,
   output cmd_e             cmd
);

   if (LEN_W < 2) begin : g_bad_len
      $error("cpage_cmd_arb: LEN_W must be at least 2");
   end

   logic sel_ok;
   assign sel_ok = sel_valid && (sel_len != '0);

   always_comb begin
      if (clr_cmd)      cmd = CMD_CLR;
      else if (pop_cmd) cmd = CMD_POP;
      else if (sel_ok)  cmd = CMD_PUSH;
      else              cmd = CMD_NONE;
   end

   // R9: a select never wins over a clear or a pop
   p_cmd_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd || pop_cmd) |-> (cmd != CMD_PUSH));

   // R2: a zero-length select never becomes a push
   p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_len == '0) |-> (cmd != CMD_PUSH));

endmodule

// File: rtl/cpage_top_tick.sv
module cpage_top_tick #(
   parameter int unsigned LEN_W   = 4,
   parameter int unsigned DEP_W   = 3,
   parameter bit          PERM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEP_W-1:0] depth,
   input  logic [LEN_W-1:0] top_len,
   input  logic             retire,
   input  logic             br_taken,
   output logic             drop,
   output logic             dec_we,
   output logic [LEN_W-1:0] dec_len
);

   logic perm;
   logic live;

   if (PERM_EN) begin : g_perm
      assign perm = (top_len == {LEN_W{1'b1}});
   end else begin : g_noperm
      assign perm = 1'b0;
   end

   assign live = (depth != '0) && !perm;

   always_comb begin
      drop    = 1'b0;
      dec_we  = 1'b0;
      dec_len = top_len - LEN_W'(1);
      if (live) begin
         if (br_taken) begin
            drop = 1'b1;
         end else if (retire) begin
            if (top_len == LEN_W'(1)) drop = 1'b1;
            else                      dec_we = 1'b1;
         end
      end
   end

   // R4: a permanent top entry is neither shortened nor removed
   p_perm_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (perm && depth != '0) |-> (!drop && !dec_we));

   // R6: a taken branch never shortens the entry
   p_branch_no_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> !dec_we);

endmodule

// File: rtl/cpage_csr_map.sv
module cpage_csr_map #(
   parameter int unsigned SUB_W = 3,
   parameter int unsigned LEN_W = 4,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DEP_W = 3,
   parameter int unsigned CSR_W = 32
) (
   input  logic [DEPTH-1:0][SUB_W+LEN_W-1:0] ents,
   input  logic [DEP_W-1:0]                   depth,
   input  logic [CSR_W-1:0]                   wdata,
   output logic [CSR_W-1:0]                   rdata,
   output logic [DEPTH-1:0][SUB_W+LEN_W-1:0] w_ents,
   output logic [DEP_W-1:0]                   w_depth
);

   localparam int unsigned ENT_W  = SUB_W + LEN_W;
   localparam int unsigned DEP_LO = DEPTH * ENT_W;
   localparam int unsigned PACK_W = DEP_LO + DEP_W;

   if (PACK_W > CSR_W) begin : g_bad_fit
      $error("cpage_csr_map: packed state does not fit in CSR_W");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign rdata[i*ENT_W +: ENT_W] =
         (depth > DEP_W'(i)) ? ents[i] : '0;
      assign w_ents[i] = wdata[i*ENT_W +: ENT_W];
   end

   assign rdata[DEP_LO +: DEP_W] = depth;

   if (PACK_W < CSR_W) begin : g_pad
      assign rdata[CSR_W-1:PACK_W] = '0;
   end

   logic [DEP_W-1:0] raw_depth;
   assign raw_depth = wdata[DEP_LO +: DEP_W];
   assign w_depth   = (raw_depth > DEP_W'(DEPTH)) ? DEP_W'(DEPTH) : raw_depth;

endmodule

// File: rtl/cpage_stack_regs.sv
module cpage_stack_regs
   import cpage_pkg::*;
#(
   parameter int unsigned SUB_W = 3,
   parameter int unsigned LEN_W = 4,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DEP_W = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  cmd_e                               cmd,
   input  logic [SUB_W+LEN_W-1:0]             push_ent,
   input  logic                               drop,
   input  logic                               dec_we,
   input  logic [LEN_W-1:0]                   dec_len,
   input  logic                               csr_we,
   input  logic [DEPTH-1:0][SUB_W+LEN_W-1:0] w_ents,
   input  logic [DEP_W-1:0]                   w_depth,
   output logic [DEPTH-1:0][SUB_W+LEN_W-1:0] ents,
   output logic [DEP_W-1:0]                   depth,
   output logic                               ovf,
   output logic [SUB_W-1:0]                   top_sub,
   output logic [LEN_W-1:0]                   top_len
);

   localparam int unsigned ENT_W = SUB_W + LEN_W;

   logic [DEPTH-1:0][ENT_W-1:0] ent_q;
   logic [DEP_W-1:0]            dep_q;
   logic [DEP_W-1:0]            dep_mid;
   logic [DEP_W-1:0]            dep_nx;
   logic                        push_go;
   logic                        push_full;
   logic                        ovf_q;
   logic [DEP_W-1:0]            top_idx;

   assign top_idx = dep_q - DEP_W'(1);
   assign dep_mid = dep_q - DEP_W'(drop);

   always_comb begin
      dep_nx    = dep_mid;
      push_go   = 1'b0;
      push_full = 1'b0;
      unique case (cmd)
         CMD_CLR:  dep_nx = '0;
         CMD_POP:  if (dep_mid != '0) dep_nx = dep_mid - DEP_W'(1);
         CMD_PUSH: begin
            if (dep_mid < DEP_W'(DEPTH)) begin
               push_go = 1'b1;
               dep_nx  = dep_mid + DEP_W'(1);
            end else begin
               push_full = 1'b1;
            end
         end
         default: ;
      endcase
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q[i] <= '0;
         end else if (csr_we) begin
            ent_q[i] <= w_ents[i];
         end else if (push_go && dep_mid == DEP_W'(i)) begin
            ent_q[i] <= push_ent;
         end else if (dec_we && top_idx == DEP_W'(i)) begin
            ent_q[i][LEN_W-1:0] <= dec_len;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dep_q <= '0;
         ovf_q <= 1'b0;
      end else if (csr_we) begin
         dep_q <= w_depth;
         ovf_q <= 1'b0;
      end else begin
         dep_q <= dep_nx;
         if (push_full) ovf_q <= 1'b1;
      end
   end

   always_comb begin
      top_sub = '0;
      top_len = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (dep_q == DEP_W'(i + 1)) begin
            top_sub = ent_q[i][ENT_W-1:LEN_W];
            top_len = ent_q[i][LEN_W-1:0];
         end
      end
   end

   assign ents  = ent_q;
   assign depth = dep_q;
   assign ovf   = ovf_q;

   // R3: the depth never exceeds the stack size
   p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dep_q <= DEP_W'(DEPTH));

   // R3: a select at full raises the flag
   p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PUSH && dep_mid == DEP_W'(DEPTH) && !csr_we) |=> ovf_q);

   // R3: the flag is sticky until a control-word write
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !csr_we) |=> ovf_q);

   // R8: a clear leaves the stack empty
   p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_CLR && !csr_we) |=> (dep_q == '0));

   // R7: a pop with no other removal takes exactly one entry
   p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_POP && !csr_we && !drop && dep_q != '0)
      |=> (dep_q == $past(dep_q) - DEP_W'(1)));

endmodule

// File: rtl/cpage_ctrl.sv
module cpage_ctrl
   import cpage_pkg::*;
#(
   parameter int unsigned SUB_W   = 3,
   parameter int unsigned LEN_W   = 4,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned CSR_W   = 32,
   parameter bit          PERM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_valid,
   input  logic [SUB_W-1:0] sel_sub,
   input  logic [LEN_W-1:0] sel_len,
   input  logic             pop_cmd,
   input  logic             clr_cmd,
   input  logic             retire,
   input  logic             br_taken,
   input  logic             csr_we,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   output logic [SUB_W-1:0] act_sub,
   output logic             page_active,
   output logic             ovf
);

   localparam int unsigned ENT_W  = SUB_W + LEN_W;
   localparam int unsigned DEP_W  = depth_bits(DEPTH);
   localparam int unsigned DEP_LO = DEPTH * ENT_W;

   if (DEPTH < 1) begin : g_bad_depth
      $error("cpage_ctrl: DEPTH must be at least 1");
   end

   cmd_e                        cmd;
   logic                        drop;
   logic                        dec_we;
   logic [LEN_W-1:0]            dec_len;
   logic [DEPTH-1:0][ENT_W-1:0] ents;
   logic [DEPTH-1:0][ENT_W-1:0] w_ents;
   logic [DEP_W-1:0]            depth;
   logic [DEP_W-1:0]            w_depth;
   logic [SUB_W-1:0]            top_sub;
   logic [LEN_W-1:0]            top_len;

   cpage_cmd_arb #(.LEN_W(LEN_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_cmd   (clr_cmd),
      .pop_cmd   (pop_cmd),
      .sel_valid (sel_valid),
      .sel_len   (sel_len),
      .cmd       (cmd)
   );

   cpage_top_tick #(.LEN_W(LEN_W), .DEP_W(DEP_W), .PERM_EN(PERM_EN)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .depth    (depth),
      .top_len  (top_len),
      .retire   (retire),
      .br_taken (br_taken),
      .drop     (drop),
      .dec_we   (dec_we),
      .dec_len  (dec_len)
   );

   cpage_stack_regs #(
      .SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .DEP_W(DEP_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .push_ent ({sel_sub, sel_len}),
      .drop     (drop),
      .dec_we   (dec_we),
      .dec_len  (dec_len),
      .csr_we   (csr_we),
      .w_ents   (w_ents),
      .w_depth  (w_depth),
      .ents     (ents),
      .depth    (depth),
      .ovf      (ovf),
      .top_sub  (top_sub),
      .top_len  (top_len)
   );

   cpage_csr_map #(
      .SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .DEP_W(DEP_W), .CSR_W(CSR_W)
   ) u_map (
      .ents    (ents),
      .depth   (depth),
      .wdata   (csr_wdata),
      .rdata   (csr_rdata),
      .w_ents  (w_ents),
      .w_depth (w_depth)
   );

   assign page_active = (depth != '0);
   assign act_sub     = page_active ? top_sub : '0;

   // R12: an empty stack shows subpage 0
   p_idle_sub_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !page_active |-> (act_sub == '0));

   // R11: an in-range depth written by software is what reads back
   p_csr_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_wdata[DEP_LO +: DEP_W] <= DEP_W'(DEPTH))
      |=> (csr_rdata[DEP_LO +: DEP_W] == $past(csr_wdata[DEP_LO +: DEP_W])));

   // R11: a control-word write clears the overflow flag
   p_csr_clr_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |=> !ovf);

   // R2: an accepted select shows its subpage next cycle
   p_push_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_len != '0 && !clr_cmd && !pop_cmd && !csr_we &&
       !br_taken && !retire && depth < DEP_W'(DEPTH))
      |=> (act_sub == $past(sel_sub) && page_active));

endmodule

// File: tb/cpage_ctrl_tb.sv
`timescale 1ns/1ps
module cpage_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_valid = 1'b0;
   logic [2:0]  sel_sub = '0;
   logic [3:0]  sel_len = '0;
   logic        pop_cmd = 1'b0;
   logic        clr_cmd = 1'b0;
   logic        retire = 1'b0;
   logic        br_taken = 1'b0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic [2:0]  act_sub;
   logic        page_active;
   logic        ovf;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [2:0] m_sub [4];
   logic [3:0] m_len [4];
   int         m_dep = 0;
   logic       m_ovf = 1'b0;

   logic [36:0] exp_q [$];
   string       tag_q [$];
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   cpage_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_sub(sel_sub),
      .sel_len(sel_len), .pop_cmd(pop_cmd), .clr_cmd(clr_cmd), .retire(retire),
      .br_taken(br_taken), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .act_sub(act_sub), .page_active(page_active),
      .ovf(ovf)
   );

   function automatic logic [36:0] model_out();
      logic [31:0] w = '0;
      logic [2:0]  s = '0;
      for (int i = 0; i < m_dep; i++) w[i*7 +: 7] = {m_sub[i], m_len[i]};
      w[30:28] = 3'(m_dep);
      if (m_dep > 0) s = m_sub[m_dep-1];
      return {w, s, (m_dep > 0), m_ovf};
   endfunction

   task automatic step(input bit sv, input logic [2:0] s, input logic [3:0] l,
                       input bit pp, input bit cl, input bit rt, input bit bt,
                       input bit we, input logic [31:0] wd, input string tag);
      @(negedge clk);
      sel_valid = sv; sel_sub = s; sel_len = l; pop_cmd = pp; clr_cmd = cl;
      retire = rt; br_taken = bt; csr_we = we; csr_wdata = wd;
      if (we) begin
         for (int i = 0; i < 4; i++) begin
            m_len[i] = wd[i*7 +: 4];
            m_sub[i] = wd[i*7+4 +: 3];
         end
         m_dep = (wd[30:28] > 3'd4) ? 4 : int'(wd[30:28]);
         m_ovf = 1'b0;
      end else begin
         if (m_dep > 0 && m_len[m_dep-1] != 4'hF) begin
            if (bt) m_dep--;
            else if (rt) begin
               if (m_len[m_dep-1] == 4'd1) m_dep--;
               else m_len[m_dep-1] = m_len[m_dep-1] - 4'd1;
            end
         end
         if (cl) m_dep = 0;
         else if (pp) begin
            if (m_dep > 0) m_dep--;
         end else if (sv && l != 4'd0) begin
            if (m_dep < 4) begin
               m_sub[m_dep] = s; m_len[m_dep] = l; m_dep++;
            end else m_ovf = 1'b1;
         end
      end
      exp_q.push_back(model_out());
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 3'd0, 4'd0, 0, 0, 0, 0, 0, 32'd0, tag);
   endtask

   task automatic push(input logic [2:0] s, input logic [3:0] l, input string tag);
      step(1, s, l, 0, 0, 0, 0, 0, 32'd0, tag);
   endtask

   // monitor: compare one expected item after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [36:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({csr_rdata, act_sub, page_active, ovf} !== e) begin
               n_bad++;
               $display("FAIL %s: got csr=%h sub=%0d act=%0b ovf=%0b exp csr=%h sub=%0d act=%0b ovf=%0b",
                        t, csr_rdata, act_sub, page_active, ovf,
                        e[36:5], e[4:2], e[1], e[0]);
            end
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_sub[i] = '0; m_len[i] = '0; end
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if ({csr_rdata, act_sub, page_active, ovf} !== 37'd0) begin
         n_bad++;
         $display("FAIL R1 in reset: got csr=%h exp 0", csr_rdata);
      end
      @(negedge clk); rst_n = 1'b1;
      idle("R1 after reset");

      push(3'd5, 4'd3, "R2 push");
      push(3'd6, 4'd0, "R2 zero length ignored");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5 retire dec");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5 retire dec");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5 retire expiry pops");
      idle("R12 empty");

      push(3'd2, 4'hF, "R2 push permanent");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R4 retire on permanent");
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 branch on permanent");
      push(3'd3, 4'd4, "R2 push over permanent");
      step(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6 branch with retire");
      push(3'd7, 4'd2, "R2 push");
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R6 branch pops");

      push(3'd1, 4'd9, "R10 fill");
      push(3'd4, 4'd1, "R10 fill");
      push(3'd6, 4'd7, "R10 fill full");
      push(3'd0, 4'd5, "R3 push at full");
      idle("R3 sticky");
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 pop");
      step(1, 3'd5, 4'd6, 0, 0, 0, 1, 0, 0, "R9 branch then select");
      step(1, 3'd5, 4'd6, 1, 0, 1, 0, 0, 0, "R9 pop beats select");
      step(1, 3'd1, 4'd3, 1, 1, 0, 0, 0, 0, "R9 clear beats all");
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 pop at empty");
      idle("R3 still sticky");

      step(1, 3'd2, 4'd2, 0, 1, 1, 1, 1, 32'h7FFF_FFFF, "R11 write saturates");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5 retire after write");
      step(0, 0, 0, 0, 0, 0, 0, 1, {1'b1, 3'd2, 14'd0, 7'h3F, 7'h52}, "R11 write depth 2");
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 pop restores below");
      push(3'd4, 4'd1, "R10 push over restored");
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 clear");
      idle("R12 empty after clear");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule